// File: doc/BRIEF.md
# Four-Phase Handshake Sequencing Controller

This controller links a passive left channel to an active right channel, both running a four-phase return-to-zero protocol. When the left side requests, the controller runs one full request/acknowledge/release cycle on the right side. Only after the right side has returned to zero does it acknowledge the left side, and it then waits for the left side to release. The right handshake therefore sits entirely inside the left one. It is used to sequence one downstream operation per upstream token.

The block is a clocked state machine whose transitions follow guarded production rules. An internal bit `x` marks the second half of the cycle. This lets the machine tell apart the two phases in which both right-side wires are low. Both incoming request/acknowledge wires pass through a configurable multi-flop synchroniser before the machine sees them. Every output changes on the first clock edge at which its guard holds.

States and transitions:
- IDLE → RREQ when the synchronised left request is high (raise `rreq_o`).
- RREQ → XSET when the synchronised right acknowledge is high (set `x`).
- XSET → RREL unconditionally, because the guard "x high or left request low" holds (lower `rreq_o`).
- RREL → LACK when the synchronised right acknowledge is low (raise `lack_o`).
- LACK → XCLR when the synchronised left request is low (clear `x`).
- XCLR → IDLE unconditionally, because the guard "right acknowledge high or x low" holds (lower `lack_o`).

Top module: `hs_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `rreq_o` and `lack_o` to 0 on the next clock edge, from any state, and returns the machine to IDLE.
- R2: From IDLE, with the default two synchroniser stages, `rreq_o` rises on the third rising clock edge after `lreq_i` rises, while `lack_o` stays 0.
- R3: `rreq_o` stays high for as long as `rack_i` stays low, and falls on the fourth rising edge after `rack_i` rises. One edge is spent setting `x`.
- R4: `lack_o` rises on the third rising edge after `rack_i` falls. At that moment `rreq_o` is already 0.
- R5: `lack_o` stays high while `lreq_i` stays high, and falls on the fourth rising edge after `lreq_i` falls. One edge is spent clearing `x`.
- R6: Each left handshake contains exactly one rising edge of `rreq_o` and exactly one rising edge of `lack_o`. `rreq_o` and `lack_o` are never both high.
- R7: After `lack_o` has fallen, `rreq_o` stays 0 for as long as `lreq_i` stays low.
- R8: The environment is legal when the synchronised left request falls only while `lack_o` is high, and the synchronised right acknowledge rises only while `rreq_o` is high and falls only while `rreq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_i | input | 1 | Left channel request (asynchronous) |
| lack_o | output | 1 | Left channel acknowledge |
| rreq_o | output | 1 | Right channel request |
| rack_i | input | 1 | Right channel acknowledge (asynchronous) |

## Verification
The assertions assume that both environments obey the four-phase protocol. The left side drops its request only after seeing the acknowledge, and the right side changes its acknowledge only in the direction the current request asks for. Both inputs are also assumed to be held long enough to pass the synchroniser. The bench keeps within these limits by reacting only to observed output levels. It inserts swept and random wait times before each response, and it deasserts both inputs while reset is applied mid-handshake.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    // Controller states; x is high in XSET, RREL and LACK.
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RREQ = 3'd1,
        S_XSET = 3'd2,
        S_RREL = 3'd3,
        S_LACK = 3'd4,
        S_XCLR = 3'd5
    } hs_state_e;

    localparam int unsigned HS_MIN_SYNC = 2;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lreq_s,
    input  logic rack_s,
    output logic rreq,
    output logic lack,
    output logic xbit
);
    hs_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Guarded rules, one firing per edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (lreq_s)  state_d = S_RREQ;  // ~x & Lr -> Rr+
            S_RREQ: if (rack_s)  state_d = S_XSET;  // Ra -> x+
            S_XSET:              state_d = S_RREL;  // x | ~Lr -> Rr-
            S_RREL: if (!rack_s) state_d = S_LACK;  // x & ~Ra -> La+
            S_LACK: if (!lreq_s) state_d = S_XCLR;  // ~Lr -> x-
            S_XCLR:              state_d = S_IDLE;  // Ra | ~x -> La-
            default:             state_d = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        rreq = 1'b0;
        lack = 1'b0;
        xbit = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_RREQ: rreq = 1'b1;
            S_XSET: begin rreq = 1'b1; xbit = 1'b1; end
            S_RREL: xbit = 1'b1;
            S_LACK: begin lack = 1'b1; xbit = 1'b1; end
            S_XCLR: lack = 1'b1;
            default: ;
        endcase
    end

    // R1: reset clears both outputs on the next edge
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (!rreq && !lack));

    // R2: a right request starts only from a seen left request with La low
    p_rreq_from_lreq_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(rreq) |-> ($past(lreq_s) && !lack && !xbit));

    // R3: right request drops only after x has been set
    p_rreq_fall_after_x_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(rreq) |-> ($past(xbit) && xbit));

    // R4: left acknowledge rises only with right channel back at zero
    p_lack_after_rtz_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(lack) |-> (!rreq && !$past(rack_s) && $past(xbit)));

    // R5: left acknowledge falls only after x cleared
    p_lack_fall_after_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(lack) |-> ($past(!xbit) && !$past(lreq_s)));

    // R6: the two outputs are exclusive
    p_outputs_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(rreq && lack));

    // R8: environment legality
    p_lreq_fall_legal_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(lreq_s) |-> lack);
    p_rack_rise_legal_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rack_s) |-> rreq);
    p_rack_fall_legal_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rack_s) |-> !rreq);

endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl
    import hs_seq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lreq_i,
    output logic lack_o,
    output logic rreq_o,
    input  logic rack_i
);
    localparam int unsigned STG = (SYNC_STAGES < HS_MIN_SYNC) ? HS_MIN_SYNC : SYNC_STAGES;

    logic lreq_s;
    logic rack_s;
    logic x_unused;

    hs_sync #(.STAGES(STG)) u_sync_l (
        .clk (clk),
        .rst (rst),
        .d_i (lreq_i),
        .q_o (lreq_s)
    );

    hs_sync #(.STAGES(STG)) u_sync_r (
        .clk (clk),
        .rst (rst),
        .d_i (rack_i),
        .q_o (rack_s)
    );

    hs_seq_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .lreq_s (lreq_s),
        .rack_s (rack_s),
        .rreq   (rreq_o),
        .lack   (lack_o),
        .xbit   (x_unused)
    );

    // R7: with left request low after the cycle, no new right request
    p_no_spurious_rreq_r7: assert property (@(posedge clk) disable iff (rst)
        (!lreq_s && !rreq_o) |=> !rreq_o);

endmodule

// File: tb/tb_hs_seq_ctrl.sv
module tb_hs_seq_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lreq_i = 1'b0;
    logic rack_i = 1'b0;
    logic lack_o;
    logic rreq_o;

    int n_chk = 0;
    int n_fail = 0;
    int rr_rises = 0;
    int la_rises = 0;
    logic rr_prev = 1'b0;
    logic la_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hs_seq_ctrl dut (
        .clk    (clk),
        .rst    (rst),
        .lreq_i (lreq_i),
        .lack_o (lack_o),
        .rreq_o (rreq_o),
        .rack_i (rack_i)
    );

    always @(posedge clk) begin
        rr_prev <= rreq_o;
        la_prev <= lack_o;
        if (rreq_o && !rr_prev) rr_rises <= rr_rises + 1;
        if (lack_o && !la_prev) la_rises <= la_rises + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Counts falling edges until rreq_o reaches val (limit 60)
    task automatic wait_rr(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rreq_o !== val && n < 60);
    endtask

    task automatic wait_la(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (lack_o !== val && n < 60);
    endtask

    task automatic txn(input int gap, input int rd1, input int rd2, input int ld);
        int n;
        int rr0;
        int la0;
        rr0 = rr_rises;
        la0 = la_rises;
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            chk(rreq_o == 1'b0, "R7 idle rreq", rreq_o, 0);
        end
        lreq_i = 1'b1;
        wait_rr(1'b1, n);
        chk(n == 3, "R2 rreq latency", n, 3);
        chk(lack_o == 1'b0, "R2 lack low at rreq", lack_o, 0);
        for (int i = 0; i < rd1; i++) begin
            @(negedge clk);
            chk(rreq_o == 1'b1, "R3 rreq held", rreq_o, 1);
        end
        rack_i = 1'b1;
        wait_rr(1'b0, n);
        chk(n == 4, "R3 rreq fall latency", n, 4);
        for (int i = 0; i < rd2; i++) begin
            @(negedge clk);
            chk(lack_o == 1'b0, "R4 lack waits for rack low", lack_o, 0);
        end
        rack_i = 1'b0;
        wait_la(1'b1, n);
        chk(n == 3, "R4 lack latency", n, 3);
        chk(rreq_o == 1'b0, "R4 rreq low at lack", rreq_o, 0);
        for (int i = 0; i < ld; i++) begin
            @(negedge clk);
            chk(lack_o == 1'b1, "R5 lack held", lack_o, 1);
        end
        lreq_i = 1'b0;
        wait_la(1'b0, n);
        chk(n == 4, "R5 lack fall latency", n, 4);
        chk(rr_rises - rr0 == 1, "R6 one rreq per token", rr_rises - rr0, 1);
        chk(la_rises - la0 == 1, "R6 one lack per token", la_rises - la0, 1);
        @(negedge clk);
        chk(rreq_o == 1'b0, "R7 no rreq after cycle", rreq_o, 0);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        chk(rreq_o == 1'b0 && lack_o == 1'b0, "R1 reset state", {rreq_o, lack_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // sweep of environment wait times
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++)
                    txn((a + c) % 3, a, b, c);
        // random environment waits
        for (int k = 0; k < 1000; k++)
            txn($urandom_range(0, 5), $urandom_range(0, 6),
                $urandom_range(0, 6), $urandom_range(0, 6));
        // reset in the middle of a handshake (left acknowledged)
        lreq_i = 1'b1;
        wait_rr(1'b1, n);
        rack_i = 1'b1;
        wait_rr(1'b0, n);
        rack_i = 1'b0;
        wait_la(1'b1, n);
        rst = 1'b1;
        lreq_i = 1'b0;
        @(negedge clk);
        chk(rreq_o == 1'b0 && lack_o == 1'b0, "R1 reset mid-cycle", {rreq_o, lack_o}, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset during right request
        txn(2, 1, 1, 1);
        lreq_i = 1'b1;
        wait_rr(1'b1, n);
        rst = 1'b1;
        lreq_i = 1'b0;
        @(negedge clk);
        chk(rreq_o == 1'b0 && lack_o == 1'b0, "R1 reset during rreq", {rreq_o, lack_o}, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        txn(1, 2, 0, 3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule